// File: doc/BRIEF.md
# Host Word Port

This block is a slave port that connects an external host with an 8-bit bus to an internal processor core that works in 24-bit words. Each direction uses three byte registers: high, middle and low. The host reads a word that the core posted. The host also writes a word that the core then collects. A full flag and an empty flag pace the two directions. The host can also post a command with a vector for the core to service.

A 16-bit port control register on the core side decides what the eight pins do. They can be unused, a plain data bus with separate address lines, a bus that carries address and data on the same pins, or general-purpose I/O. In the I/O case each pin's direction comes from its own bit in a direction register. The host strobes, address, latch enable and pin inputs are asynchronous to the core clock. They pass through a two-flop synchronizer before any core logic sees them. A write acts when the synchronized write strobe asserts. A read's side effect acts when the synchronized read strobe deasserts.

Top module: `hwp_port`

## Requirements
- R1: After reset the pin mode is unused (control bits [1:0] = 0): pin_oe is 0, core_tx_ready is 1, core_rx_valid is 0 and cmd_pending is 0. In this mode host strobes have no effect.
- R2: When core_tx_valid is high and the receive bytes are empty, the core word is loaded and core_tx_ready drops. While the word is unread, the host reads its high, middle and low bytes at addresses 5, 6 and 7.
- R3: The receive-full state ends only when a host read of address 7 completes. Reading addresses 5 or 6 leaves it set.
- R4: Host writes to addresses 5 and 6 stage the high and middle bytes. A write to address 7 puts {high, middle, written byte} on core_rx_word, raises core_rx_valid and clears the transmit-empty state.
- R5: While core_rx_valid is high, host writes to addresses 5, 6 and 7 are ignored and core_rx_word holds. A core_rx_take pulse restores the transmit-empty state.
- R6: A host write to address 1 sets cmd_pending from bit 7 and cmd_vector from bits 6:0. While cmd_pending is high, further writes to address 1 are ignored. cmd_ack clears cmd_pending.
- R7: A host read of address 0 returns a status byte: bit 0 is receive full, bit 1 is transmit empty, bit 2 is command pending, and the other bits are 0.
- R8: In multiplexed mode (control bits [1:0] = 2), the register address is taken from pin_in[2:0] while hst_ale is high. hst_addr is ignored, and data uses the same pins.
- R9: In I/O mode (control bits [1:0] = 3), pin_oe equals the direction register, pin_out equals gpio_dout, gpio_din follows pin_in, and host strobes have no effect.
- R10: In plain bus mode (control bits [1:0] = 1), hst_addr selects the register. During a host read (hst_cs_n and hst_rd_n low) pin_oe is 8'hFF and pin_out carries the selected byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_cs_n | input | 1 | Host chip select, active low |
| hst_rd_n | input | 1 | Host read strobe, active low |
| hst_wr_n | input | 1 | Host write strobe, active low |
| hst_ale | input | 1 | Address latch enable for multiplexed mode |
| hst_addr | input | 3 | Register address in plain bus mode |
| pin_in | input | 8 | Pin input values |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| cfg_ctrl_we | input | 1 | Write strobe for the port control register |
| cfg_dir_we | input | 1 | Write strobe for the direction register |
| cfg_wdata | input | 16 | Configuration write data |
| gpio_dout | input | 8 | Output values in I/O mode |
| gpio_din | output | 8 | Synchronized pin values in I/O mode |
| core_tx_word | input | 24 | Word from the core to the host |
| core_tx_valid | input | 1 | Core offers core_tx_word |
| core_tx_ready | output | 1 | Receive bytes are empty |
| core_rx_word | output | 24 | Word written by the host |
| core_rx_valid | output | 1 | Host word waiting for the core |
| core_rx_take | input | 1 | Core has taken core_rx_word |
| cmd_pending | output | 1 | Host command pending |
| cmd_vector | output | 7 | Host command vector |
| cmd_ack | input | 1 | Core acknowledges the command |

## Verification
The bench reads the high and middle bytes first and confirms that the receive-full state survives both reads. A design that cleared it early would let the core overwrite a half-read word. It writes the low byte a second time while the core has not yet taken the first word. A design that accepted that write would corrupt core_rx_word. It rewrites the command register while a command is pending, and drives strobes in the unused and I/O modes. A design that let the vector move, or acted on strobes in a non-bus mode, would show a changed vector or a spurious core_rx_valid. The multiplexed tests drive a wrong value on hst_addr, so a design that decoded the wrong address source would return the wrong byte.

// File: rtl/hwp_pkg.sv
package hwp_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 3;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;
  localparam int ADDR_W     = 3;
  localparam int VEC_W      = BYTE_W - 1;

  typedef enum logic [1:0] {
    PM_OFF  = 2'd0,
    PM_DATA = 2'd1,
    PM_MUX  = 2'd2,
    PM_GPIO = 2'd3
  } pin_mode_e;

  localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_HI   = 3'd5;
  localparam logic [ADDR_W-1:0] A_MID  = 3'd6;
  localparam logic [ADDR_W-1:0] A_LO   = 3'd7;

  function automatic logic [WORD_W-1:0] join_word(input logic [BYTE_W-1:0] h,
                                                   input logic [BYTE_W-1:0] m,
                                                   input logic [BYTE_W-1:0] l);
    return {h, m, l};
  endfunction

  function automatic logic [BYTE_W-1:0] status_byte(input logic full_f,
                                                    input logic empty_f,
                                                    input logic cmd_f);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[0] = full_f;
    s[1] = empty_f;
    s[2] = cmd_f;
    return s;
  endfunction
endpackage

// File: rtl/hwp_sync.sv
module hwp_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hwp_regs.sv
module hwp_regs
  import hwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic              rd_end_evt,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic [WORD_W-1:0] core_tx_word,
  input  logic              core_tx_valid,
  output logic              core_tx_ready,
  output logic [WORD_W-1:0] core_rx_word,
  output logic              core_rx_valid,
  input  logic              core_rx_take,
  output logic              cmd_pending,
  output logic [VEC_W-1:0]  cmd_vector,
  input  logic              cmd_ack
);
  logic [BYTE_W-1:0] rx_hi, rx_mid, rx_lo;
  logic [BYTE_W-1:0] tx_hi, tx_mid;
  logic              rx_full, tx_empty;

  wire rx_load     = core_tx_valid && !rx_full;
  wire rd_low_done = rd_end_evt && (reg_addr == A_LO);
  wire tx_wr_ok    = wr_evt && tx_empty;
  wire tx_low_wr   = tx_wr_ok && (reg_addr == A_LO);
  wire cmd_wr_ok   = wr_evt && (reg_addr == A_CMD) && !cmd_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_hi <= '0; rx_mid <= '0; rx_lo <= '0;
      rx_full <= 1'b0;
    end else if (rx_load) begin
      {rx_hi, rx_mid, rx_lo} <= core_tx_word;
      rx_full <= 1'b1;
    end else if (rd_low_done) begin
      rx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hi <= '0; tx_mid <= '0;
      core_rx_word <= '0;
      tx_empty <= 1'b1;
    end else if (tx_wr_ok) begin
      if (reg_addr == A_HI)  tx_hi  <= wdata;
      if (reg_addr == A_MID) tx_mid <= wdata;
      if (tx_low_wr) begin
        core_rx_word <= join_word(tx_hi, tx_mid, wdata);
        tx_empty     <= 1'b0;
      end
    end else if (core_rx_take && !tx_empty) begin
      tx_empty <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_pending <= 1'b0;
      cmd_vector  <= '0;
    end else if (cmd_wr_ok) begin
      cmd_pending <= wdata[BYTE_W-1];
      cmd_vector  <= wdata[VEC_W-1:0];
    end else if (cmd_ack) begin
      cmd_pending <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  rdata = status_byte(rx_full, tx_empty, cmd_pending);
      A_CMD:   rdata = {cmd_pending, cmd_vector};
      A_HI:    rdata = rx_hi;
      A_MID:   rdata = rx_mid;
      A_LO:    rdata = rx_lo;
      default: rdata = '0;
    endcase
  end

  assign core_tx_ready = !rx_full;
  assign core_rx_valid = !tx_empty;

  assert_rx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_tx_valid && core_tx_ready) |=> (rx_full && rx_lo == $past(core_tx_word[BYTE_W-1:0])));
  assert_full_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> $past(rd_low_done));
  assert_empty_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) |-> $past(wr_evt && reg_addr == A_LO));
  assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rx_valid && $past(core_rx_valid)) |-> $stable(core_rx_word));
  assert_vec_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pending && $past(cmd_pending)) |-> $stable(cmd_vector));
endmodule

// File: rtl/hwp_port.sv
module hwp_port
  import hwp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_cs_n,
  input  logic              hst_rd_n,
  input  logic              hst_wr_n,
  input  logic              hst_ale,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [BYTE_W-1:0] pin_in,
  output logic [BYTE_W-1:0] pin_out,
  output logic [BYTE_W-1:0] pin_oe,
  input  logic              cfg_ctrl_we,
  input  logic              cfg_dir_we,
  input  logic [15:0]       cfg_wdata,
  input  logic [BYTE_W-1:0] gpio_dout,
  output logic [BYTE_W-1:0] gpio_din,
  input  logic [WORD_W-1:0] core_tx_word,
  input  logic              core_tx_valid,
  output logic              core_tx_ready,
  output logic [WORD_W-1:0] core_rx_word,
  output logic              core_rx_valid,
  input  logic              core_rx_take,
  output logic              cmd_pending,
  output logic [VEC_W-1:0]  cmd_vector,
  input  logic              cmd_ack
);
  localparam int DW = ADDR_W + BYTE_W;

  logic              s_cs_n, s_rd_n, s_wr_n, s_ale;
  logic [ADDR_W-1:0] s_addr;
  logic [BYTE_W-1:0] s_pin;
  logic [DW-1:0]     s_data;

  hwp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1110)) i_sync_ctl (
    .clk(clk), .rst_n(rst_n),
    .d({hst_cs_n, hst_rd_n, hst_wr_n, hst_ale}),
    .q({s_cs_n, s_rd_n, s_wr_n, s_ale}));

  hwp_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_sync_dat (
    .clk(clk), .rst_n(rst_n), .d({hst_addr, pin_in}), .q(s_data));

  assign {s_addr, s_pin} = s_data;

  pin_mode_e         mode_q;
  logic [BYTE_W-1:0] dir_q;
  logic [ADDR_W-1:0] lat_addr;
  logic              wr_prev, rd_prev;
  logic              unused_cfg;

  assign unused_cfg = ^cfg_wdata[15:BYTE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_OFF;
      dir_q  <= '0;
    end else begin
      if (cfg_ctrl_we) mode_q <= pin_mode_e'(cfg_wdata[1:0]);
      if (cfg_dir_we)  dir_q  <= cfg_wdata[BYTE_W-1:0];
    end
  end

  wire bus_mode = (mode_q == PM_DATA) || (mode_q == PM_MUX);
  wire acc_wr   = bus_mode && !s_cs_n && !s_wr_n;
  wire acc_rd   = bus_mode && !s_cs_n && !s_rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr <= '0;
      wr_prev  <= 1'b0;
      rd_prev  <= 1'b0;
    end else begin
      if (mode_q == PM_MUX && s_ale) lat_addr <= s_pin[ADDR_W-1:0];
      wr_prev <= acc_wr;
      rd_prev <= acc_rd;
    end
  end

  wire               wr_evt     = acc_wr && !wr_prev;
  wire               rd_end_evt = !acc_rd && rd_prev;
  wire [ADDR_W-1:0]  eff_addr   = (mode_q == PM_MUX) ? lat_addr : s_addr;
  logic [BYTE_W-1:0] rdata;

  hwp_regs i_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_evt(wr_evt), .rd_end_evt(rd_end_evt),
    .reg_addr(eff_addr), .wdata(s_pin), .rdata(rdata),
    .core_tx_word(core_tx_word), .core_tx_valid(core_tx_valid),
    .core_tx_ready(core_tx_ready),
    .core_rx_word(core_rx_word), .core_rx_valid(core_rx_valid),
    .core_rx_take(core_rx_take),
    .cmd_pending(cmd_pending), .cmd_vector(cmd_vector), .cmd_ack(cmd_ack));

  always_comb begin
    if (mode_q == PM_GPIO) begin
      pin_oe   = dir_q;
      pin_out  = gpio_dout;
      gpio_din = s_pin;
    end else begin
      pin_oe   = acc_rd ? '1 : '0;
      pin_out  = rdata;
      gpio_din = '0;
    end
  end

  assert_quiet_modes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_OFF || mode_q == PM_GPIO) |=> !$rose(core_rx_valid));
  assert_gpio_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_GPIO && $stable(mode_q)) |-> !wr_evt);
endmodule

// File: tb/test_hwp_port.sv
module test_hwp_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hst_cs_n = 1'b1, hst_rd_n = 1'b1, hst_wr_n = 1'b1, hst_ale = 1'b0;
  logic [2:0]  hst_addr = '0;
  logic [7:0]  pin_in = '0, pin_out, pin_oe;
  logic        cfg_ctrl_we = 1'b0, cfg_dir_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [7:0]  gpio_dout = '0, gpio_din;
  logic [23:0] core_tx_word = '0, core_rx_word;
  logic        core_tx_valid = 1'b0, core_tx_ready, core_rx_valid, core_rx_take = 1'b0;
  logic        cmd_pending, cmd_ack = 1'b0;
  logic [6:0]  cmd_vector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hwp_port i_hwp_port (.*);

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input bit dir, input logic [15:0] v);
    @(negedge clk);
    cfg_wdata = v;
    if (dir) cfg_dir_we = 1'b1; else cfg_ctrl_we = 1'b1;
    @(negedge clk);
    cfg_dir_we = 1'b0; cfg_ctrl_we = 1'b0;
  endtask

  task automatic pulse_core(input int which);
    @(negedge clk);
    case (which)
      0: core_tx_valid = 1'b1;
      1: core_rx_take  = 1'b1;
      default: cmd_ack = 1'b1;
    endcase
    @(negedge clk);
    core_tx_valid = 1'b0; core_rx_take = 1'b0; cmd_ack = 1'b0;
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    hst_addr = a; pin_in = d; hst_cs_n = 1'b0;
    cycles(1); hst_wr_n = 1'b0;
    cycles(4); hst_wr_n = 1'b1; hst_cs_n = 1'b1;
    cycles(4);
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [7:0] d, output logic [7:0] oe);
    hst_addr = a; hst_cs_n = 1'b0;
    cycles(1); hst_rd_n = 1'b0;
    cycles(4); d = pin_out; oe = pin_oe;
    hst_rd_n = 1'b1; hst_cs_n = 1'b1;
    cycles(4);
  endtask

  task automatic mux_latch(input logic [2:0] a);
    hst_addr = ~a; pin_in = {5'b0, a}; hst_ale = 1'b1;
    cycles(4); hst_ale = 1'b0;
    cycles(4);
  endtask

  function automatic logic [7:0] stat(input bit full_f, input bit empty_f, input bit cmd_f);
    return {5'b0, cmd_f, empty_f, full_f};
  endfunction

  task automatic t_reset_state();
    check("R1 pin_oe after reset", pin_oe, 0);
    check("R1 core_tx_ready after reset", core_tx_ready, 1);
    check("R1 core_rx_valid after reset", core_rx_valid, 0);
    check("R1 cmd_pending after reset", cmd_pending, 0);
    host_wr(3'd7, 8'h44);
    check("R1 strobe ignored when unused", core_rx_valid, 0);
  endtask

  task automatic t_host_to_core();
    logic [7:0] d, oe;
    host_rd(3'd0, d, oe);
    check("R7 idle status", d, stat(0, 1, 0));
    check("R10 read drives pins", oe, 8'hFF);
    host_wr(3'd5, 8'hAB);
    host_wr(3'd6, 8'hCD);
    check("R4 no word before low byte", core_rx_valid, 0);
    host_wr(3'd7, 8'hEF);
    check("R4 word valid", core_rx_valid, 1);
    check("R4 word value", core_rx_word, 24'hABCDEF);
    host_rd(3'd0, d, oe);
    check("R7 status tx busy", d, stat(0, 0, 0));
    host_wr(3'd5, 8'h99);
    host_wr(3'd7, 8'h11);
    check("R5 word held while busy", core_rx_word, 24'hABCDEF);
    pulse_core(1);
    check("R5 take frees transmit", core_rx_valid, 0);
    host_wr(3'd7, 8'h22);
    check("R5 staged high kept from before", core_rx_word, 24'hABCD22);
    pulse_core(1);
  endtask

  task automatic t_core_to_host();
    logic [7:0] d, oe;
    core_tx_word = 24'h123456;
    pulse_core(0);
    check("R2 ready drops on load", core_tx_ready, 0);
    host_rd(3'd0, d, oe);
    check("R7 status rx full", d, stat(1, 1, 0));
    host_rd(3'd5, d, oe);
    check("R2 high byte", d, 8'h12);
    host_rd(3'd6, d, oe);
    check("R2 middle byte", d, 8'h34);
    check("R3 full kept after high and middle", core_tx_ready, 0);
    host_rd(3'd7, d, oe);
    check("R2 low byte", d, 8'h56);
    check("R3 full cleared by low read", core_tx_ready, 1);
  endtask

  task automatic t_command();
    logic [7:0] d, oe;
    host_wr(3'd1, 8'h95);
    check("R6 command pending", cmd_pending, 1);
    check("R6 vector", cmd_vector, 7'h15);
    host_rd(3'd0, d, oe);
    check("R7 status command bit", d, stat(0, 1, 1));
    host_wr(3'd1, 8'hAA);
    check("R6 vector held while pending", cmd_vector, 7'h15);
    pulse_core(2);
    check("R6 ack clears command", cmd_pending, 0);
    host_wr(3'd1, 8'h82);
    check("R6 new vector after ack", cmd_vector, 7'h02);
    pulse_core(2);
  endtask

  task automatic t_mux();
    logic [7:0] d, oe;
    cfg(0, 16'h0002);
    mux_latch(3'd5); host_wr(3'd0, 8'h01);
    mux_latch(3'd6); host_wr(3'd0, 8'h02);
    mux_latch(3'd7); host_wr(3'd0, 8'h03);
    check("R8 multiplexed word", core_rx_word, 24'h010203);
    pulse_core(1);
    core_tx_word = 24'hA0B0C0;
    pulse_core(0);
    mux_latch(3'd6);
    host_rd(3'd0, d, oe);
    check("R8 multiplexed read middle", d, 8'hB0);
    mux_latch(3'd7);
    host_rd(3'd0, d, oe);
    check("R8 multiplexed read low", d, 8'hC0);
    check("R8 full cleared via latched address", core_tx_ready, 1);
  endtask

  task automatic t_gpio();
    cfg(1, 16'h000F);
    cfg(0, 16'h0003);
    gpio_dout = 8'h5A;
    cycles(1);
    check("R9 gpio direction", pin_oe, 8'h0F);
    check("R9 gpio output", pin_out, 8'h5A);
    pin_in = 8'hC3;
    cycles(4);
    check("R9 gpio input", gpio_din, 8'hC3);
    host_wr(3'd7, 8'h77);
    check("R9 strobe ignored in gpio", core_rx_valid, 0);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    t_reset_state();
    cfg(0, 16'h0001);
    t_host_to_core();
    t_core_to_host();
    t_command();
    t_mux();
    t_gpio();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule